// File: doc/BRIEF.md
# 1-Wire Bus Master Engine

This block is the timing engine of a 1-Wire bus master. It drives one open-drain line through a pull-low enable and reads the line back through an input sample. Each operation is one timed frame: an initialization reset that also detects whether any slave is present, a single-bit write slot, or a single-bit read slot. The host sets a two-bit operation code and, for writes, the data bit, then pulses `start`. While the frame runs, `busy` is high. `done` pulses once when the frame is over. The read bit and the presence flag keep their values until the next frame of the same kind replaces them.

All timing is counted in microseconds. A prescaler turns the system clock into a one-per-microsecond tick, and `CLKS_PER_US` sets the number of clocks per microsecond. Each phase length is a parameter in microseconds: the reset low time, the reset listen time, the presence sample point, the slot length, the recovery time, the write-1 low time, the read low time and the read sample point. Byte assembly, ROM commands and CRC checking are done by logic above this block.

Top module: `owm_engine`

## Requirements
- R1: A reset frame (`op` = 2'b00) holds `line_oe` high for exactly T_RST_LOW microseconds (480 by default), beginning the cycle after `start` is accepted.
- R2: In a reset frame, the line is sampled T_PRES_SMP (70) microseconds after release. `presence` becomes 1 if the line was low at that point and 0 if it was high.
- R3: A reset frame lasts T_RST_LOW + T_RST_REC (480 + 480) microseconds from acceptance until `done`. The line stays released for the whole listen part.
- R4: A write frame (`op` = 2'b01) with `wr_bit` = 1 drives the line low for T_W1_LOW (5) microseconds. The frame lasts T_SLOT + T_REC (60 + 1) microseconds. Every frame starts with the line driven low.
- R5: A write frame with `wr_bit` = 0 drives the line low for the whole T_SLOT (60) microseconds. It then releases the line for at least T_REC (1) microsecond before `done`.
- R6: A read frame (`op` = 2'b10) drives the line low for T_RD_LOW (2) microseconds. It samples the line into `rd_bit` at T_RD_SMP (13) microseconds and ends after T_SLOT + T_REC microseconds.
- R7: A `start` that arrives while `busy` is high is ignored. The running frame keeps its timing, and no second frame follows it.
- R8: `busy` is high from the cycle after acceptance until `done`. `done` is high for exactly one clock, in the first cycle in which `busy` is low again.
- R9: Operation code 2'b11 is not an operation. A `start` with that code leaves the block idle and the line released.
- R10: After reset, `busy`, `done`, `line_oe`, `rd_bit` and `presence` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a frame; taken only while idle |
| op | input | 2 | 00 reset, 01 write, 10 read, 11 none |
| wr_bit | input | 1 | Data bit for a write frame, captured at acceptance |
| line_in | input | 1 | Sampled level of the 1-Wire line |
| line_oe | output | 1 | 1 pulls the line low, 0 releases it |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-clock pulse at the end of a frame |
| rd_bit | output | 1 | Bit captured by the last read frame |
| presence | output | 1 | Presence result of the last reset frame |

## Verification
Every result is due at a fixed cycle count after the clock edge that accepts `start`. Call that edge E0 and let K be CLKS_PER_US:
- `line_oe` is high for exactly low-time × K cycles, starting one cycle after E0.
- `done` shows in the cycle after edge E0 + frame-length × K.
- The sampled bit is captured on edge E0 + sample-point × K.

The bench numbers the falling edges after E0 and checks the drive length, the end of the drive, the cycle in which `done` appears and how long it lasts against those formulas. The bench runs the slave pull-down from the same count, so the line is held well before and after each sample edge.

// File: rtl/owm_pkg.sv
package owm_pkg;
  typedef enum logic [1:0] {
    OP_RESET = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_NONE  = 2'b11
  } op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } state_e;
endpackage

// File: rtl/owm_tick.sv
module owm_tick #(
  parameter int CLKS_PER_US = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic tick
);
  localparam int DW = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
  localparam logic [DW-1:0] LAST = DW'(CLKS_PER_US - 1);

  logic [DW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = run && (cnt_q == LAST);
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (tick) cnt_d = '0;
    else if (run)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/owm_elapsed.sv
module owm_elapsed #(
  parameter int EW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  output logic [EW-1:0] elapsed
);
  logic [EW-1:0] cnt_d;

  always_comb begin
    cnt_d = elapsed;
    if (clr)       cnt_d = '0;
    else if (tick) cnt_d = elapsed + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) elapsed <= '0;
    else        elapsed <= cnt_d;
  end
endmodule

// File: rtl/owm_ctrl.sv
module owm_ctrl
  import owm_pkg::*;
#(
  parameter int EW         = 10,
  parameter int T_RST_LOW  = 480,
  parameter int T_RST_REC  = 480,
  parameter int T_PRES_SMP = 70,
  parameter int T_SLOT     = 60,
  parameter int T_REC      = 1,
  parameter int T_W1_LOW   = 5,
  parameter int T_RD_LOW   = 2,
  parameter int T_RD_SMP   = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    op,
  input  logic          wr_bit,
  input  logic          tick,
  input  logic [EW-1:0] elapsed,
  input  logic          line_in,
  output logic          clr,
  output logic          busy,
  output logic          done,
  output logic          rd_bit,
  output logic          presence,
  output logic          line_oe,
  output logic [1:0]    op_cur
);
  localparam logic [EW-1:0] LOW_RST  = EW'(T_RST_LOW);
  localparam logic [EW-1:0] LOW_W1   = EW'(T_W1_LOW);
  localparam logic [EW-1:0] LOW_W0   = EW'(T_SLOT);
  localparam logic [EW-1:0] LOW_RD   = EW'(T_RD_LOW);
  localparam logic [EW-1:0] SMP_RST  = EW'(T_RST_LOW + T_PRES_SMP - 1);
  localparam logic [EW-1:0] SMP_RD   = EW'(T_RD_SMP - 1);
  localparam logic [EW-1:0] END_RST  = EW'(T_RST_LOW + T_RST_REC - 1);
  localparam logic [EW-1:0] END_SLOT = EW'(T_SLOT + T_REC - 1);

  state_e        state_q, state_d;
  op_e           op_q, op_d;
  logic          bit_q, bit_d;
  logic          done_d, rd_d, pres_d;
  logic          accept, hit_end, hit_smp;
  logic [EW-1:0] low_lim, smp_pt, end_pt;

  // Per-operation limits
  always_comb begin
    unique case (op_q)
      OP_RESET: begin low_lim = LOW_RST; smp_pt = SMP_RST; end_pt = END_RST;  end
      OP_WRITE: begin low_lim = bit_q ? LOW_W1 : LOW_W0; smp_pt = '0; end_pt = END_SLOT; end
      OP_READ:  begin low_lim = LOW_RD;  smp_pt = SMP_RD;  end_pt = END_SLOT; end
      default:  begin low_lim = '0;      smp_pt = '0;      end_pt = END_SLOT; end
    endcase
  end

  assign busy    = (state_q == ST_RUN);
  assign accept  = !busy && start && (op_e'(op) != OP_NONE);
  assign clr     = accept;
  assign hit_end = busy && tick && (elapsed == end_pt);
  assign hit_smp = busy && tick && (elapsed == smp_pt);
  assign line_oe = busy && (elapsed < low_lim);
  assign op_cur  = op_q;

  // Next state
  always_comb begin
    state_d = state_q;
    op_d    = op_q;
    bit_d   = bit_q;
    done_d  = 1'b0;
    rd_d    = rd_bit;
    pres_d  = presence;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = ST_RUN;
          op_d    = op_e'(op);
          bit_d   = wr_bit;
        end
      end
      ST_RUN: begin
        if (hit_smp && op_q == OP_RESET) pres_d = !line_in;
        if (hit_smp && op_q == OP_READ)  rd_d   = line_in;
        if (hit_end) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      op_q     <= OP_NONE;
      bit_q    <= 1'b0;
      done     <= 1'b0;
      rd_bit   <= 1'b0;
      presence <= 1'b0;
    end else begin
      state_q  <= state_d;
      op_q     <= op_d;
      bit_q    <= bit_d;
      done     <= done_d;
      rd_bit   <= rd_d;
      presence <= pres_d;
    end
  end
endmodule

// File: rtl/owm_engine.sv
module owm_engine
  import owm_pkg::*;
#(
  parameter int CLKS_PER_US = 50,
  parameter int T_RST_LOW   = 480,
  parameter int T_RST_REC   = 480,
  parameter int T_PRES_SMP  = 70,
  parameter int T_SLOT      = 60,
  parameter int T_REC       = 1,
  parameter int T_W1_LOW    = 5,
  parameter int T_RD_LOW    = 2,
  parameter int T_RD_SMP    = 13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] op,
  input  logic       wr_bit,
  input  logic       line_in,
  output logic       line_oe,
  output logic       busy,
  output logic       done,
  output logic       rd_bit,
  output logic       presence
);
  localparam int MAX_US = (T_RST_LOW + T_RST_REC > T_SLOT + T_REC) ?
                          (T_RST_LOW + T_RST_REC) : (T_SLOT + T_REC);
  localparam int EW = $clog2(MAX_US + 2);

  logic          tick, clr;
  logic [EW-1:0] elapsed;
  logic [1:0]    op_cur;

  owm_tick #(.CLKS_PER_US(CLKS_PER_US)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(clr), .run(busy), .tick(tick)
  );

  owm_elapsed #(.EW(EW)) u_elapsed (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick), .elapsed(elapsed)
  );

  owm_ctrl #(
    .EW(EW), .T_RST_LOW(T_RST_LOW), .T_RST_REC(T_RST_REC),
    .T_PRES_SMP(T_PRES_SMP), .T_SLOT(T_SLOT), .T_REC(T_REC),
    .T_W1_LOW(T_W1_LOW), .T_RD_LOW(T_RD_LOW), .T_RD_SMP(T_RD_SMP)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .wr_bit(wr_bit),
    .tick(tick), .elapsed(elapsed), .line_in(line_in), .clr(clr),
    .busy(busy), .done(done), .rd_bit(rd_bit), .presence(presence),
    .line_oe(line_oe), .op_cur(op_cur)
  );
endmodule

// File: rtl/owm_engine_chk.sv
module owm_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [1:0] op,
  input logic       line_oe,
  input logic       busy,
  input logic       done,
  input logic [1:0] op_cur
);
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_ends_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_idle_released_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !line_oe);

  p_recovery_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(!line_oe));

  p_slot_starts_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> line_oe);

  p_op_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(op_cur));

  p_none_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && op == 2'b11) |=> !busy);
endmodule

bind owm_engine owm_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .op(op), .line_oe(line_oe),
  .busy(busy), .done(done), .op_cur(op_cur)
);

// File: tb/tb_owm_engine.sv
module tb_owm_engine;
  localparam int K = 10;

  logic       clk, rst_n, start, wr_bit, line_oe, busy, done, rd_bit, presence;
  logic [1:0] op;
  logic       slave_low;
  logic       line_in;
  int         checks, errors;
  bit         finished;

  assign line_in = !(line_oe || slave_low);

  owm_engine #(.CLKS_PER_US(K)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .wr_bit(wr_bit),
    .line_in(line_in), .line_oe(line_oe), .busy(busy), .done(done),
    .rd_bit(rd_bit), .presence(presence)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Run one frame; n counts falling edges after the accepting edge.
  task automatic run_op(input logic [1:0] c, input logic wb, input int s_from,
                        input int s_to, input bit inj, output int oe_cnt,
                        output int oe_last, output int done_n,
                        output int done_cnt, output int busy_bad);
    oe_cnt = 0; oe_last = 0; done_n = 0; done_cnt = 0; busy_bad = 0;
    @(negedge clk);
    start = 1'b1; op = c; wr_bit = wb;
    @(negedge clk);
    start = 1'b0;
    for (int n = 1; n < 1000 * K + 50; n++) begin
      if (n > 1) @(negedge clk);
      if (line_oe) begin oe_cnt++; oe_last = n; end
      if (done) begin done_cnt++; if (done_n == 0) done_n = n; end
      if (done_n == 0 && !busy) busy_bad++;
      if (done_n != 0 && busy) busy_bad++;
      slave_low = (n >= s_from) && (n < s_to);
      if (inj && n == 100) begin start = 1'b1; op = 2'b10; end
      if (inj && n == 101) start = 1'b0;
      if (done_n != 0 && n >= done_n + 20) break;
    end
    slave_low = 1'b0;
  endtask

  task automatic t_reset_state();
    chk(!busy && !done && !line_oe, "R10 idle outputs", {busy, done, line_oe}, 0);
    chk(!rd_bit && !presence, "R10 flags", {rd_bit, presence}, 0);
  endtask

  task automatic t_reset(input bit slave_there);
    int oc, ol, dn, dc, bb;
    run_op(2'b00, 1'b0, slave_there ? 500 * K : 0, slave_there ? 630 * K : 0,
           1'b0, oc, ol, dn, dc, bb);
    chk(oc == 480 * K && ol == 480 * K, "R1 reset low time", oc, 480 * K);
    chk(dn == 960 * K + 1, "R3 reset length", dn, 960 * K + 1);
    chk(presence == slave_there, "R2 presence flag", presence, slave_there);
    chk(dc == 1 && bb == 0, "R8 done/busy", dc * 100 + bb, 100);
  endtask

  task automatic t_write(input logic b, input bit inj);
    int oc, ol, dn, dc, bb, lo;
    lo = b ? 5 * K : 60 * K;
    run_op(2'b01, b, 0, 0, inj, oc, ol, dn, dc, bb);
    if (b) chk(oc == lo && ol == lo, "R4 write1 low time", oc, lo);
    else   chk(oc == lo && ol == lo, "R5 write0 low time", oc, lo);
    chk(dn == 61 * K + 1, inj ? "R7 slot length kept" : "R4 slot length", dn, 61 * K + 1);
    chk(dn - ol - 1 >= K, "R5 recovery", dn - ol - 1, K);
    chk(dc == 1 && bb == 0, inj ? "R7 no second frame" : "R8 done/busy",
        dc * 100 + bb, 100);
  endtask

  task automatic t_read(input logic slave_bit);
    int oc, ol, dn, dc, bb;
    run_op(2'b10, 1'b0, slave_bit ? 0 : 1, slave_bit ? 0 : 40 * K, 1'b0,
           oc, ol, dn, dc, bb);
    chk(oc == 2 * K && ol == 2 * K, "R6 read low time", oc, 2 * K);
    chk(rd_bit == slave_bit, "R6 read bit", rd_bit, slave_bit);
    chk(dn == 61 * K + 1, "R6 slot length", dn, 61 * K + 1);
  endtask

  task automatic t_none();
    int bad;
    bad = 0;
    @(negedge clk);
    start = 1'b1; op = 2'b11;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (busy || line_oe || done) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R9 code 11 ignored", bad, 0);
  endtask

  initial begin
    checks = 0; errors = 0; finished = 0;
    start = 1'b0; op = 2'b00; wr_bit = 1'b0; slave_low = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset(1'b1);
    t_reset(1'b0);
    t_write(1'b1, 1'b0);
    t_write(1'b0, 1'b0);
    t_write(1'b0, 1'b1);
    t_read(1'b0);
    t_read(1'b1);
    t_none();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule